// File: doc/BRIEF.md
# Receive Ring Buffer Write Controller

This block takes frames that have already passed address filtering and stores them into a circular buffer. The buffer lives in a byte-wide memory that is divided into 256-byte pages. Software sets up the ring with four page pointers:
- the first page of the ring;
- the page just past the last usable one;
- a boundary page, which marks how far the host has consumed frames;
- the current page, where the next frame will land.

A frame is announced with a start pulse that carries its byte length. Its bytes then arrive on a valid/ready stream. The block first decides whether the frame is admitted:
- A frame is admitted only when the receiver is not halted and the ring has room for a maximum-size frame.
- A refused frame is still drained from the stream, but no memory write is made.
- An admitted frame shorter than the minimum size is padded with zeros.

The data of an admitted frame is written four bytes into the current page and wraps from the ring end back to the ring start. A four-byte descriptor then goes into the first four bytes of that page. Last, the current page moves to the page after the frame, a status byte is latched, and a receive flag is raised for the interrupt logic.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset:
  - the current page reads 0, the receive status reads 0x00 and the receive flag is 0;
  - busy, in_ready and mem_we are 0;
  - the receiver is halted (control bit 0 = 1).
- R2: Frames are dropped while the receiver is halted. The halt bit is bit 0 of a write to select 4 (select codes: 0 first page, 1 end page, 2 boundary, 3 current page, 4 control, 5 flag clear). A dropped frame gets no memory write and leaves the current page, flag and status unchanged, but all of its bytes are still accepted from the stream.
- R3: Free space is counted in pages and then multiplied by 256:
  - when current < boundary, it is (boundary − current) pages;
  - otherwise, it is (end − first) − (current − boundary) pages.

  A frame is dropped, as in R2, when the free space is below 1518 bytes.
- R4: A frame shorter than 60 bytes is stored as 60 bytes, and bytes past its length are written as 0x00. The stored length field is the stored size + 4.
- R5: Data byte k goes to byte address current×256 + 4 + k. An address that reaches end×256 continues at first×256. An admitted frame makes exactly stored size + 4 memory writes.
- R6: The descriptor sits at byte addresses current×256 + 0..3 and holds, in this order:
  - the status byte;
  - the next page;
  - the length low byte;
  - the length high byte.
- R7: The next page is current + ceil((length + 4)/256). When that result is ≥ end, (end − first) is subtracted from it.
- R8: The status byte is 0x01. It becomes 0x21 when bit 0 of the first stored byte is 1. The rx_status port shows the status of the last stored frame.
- R9: When busy falls after an admitted frame, cur_page equals the next page and rx_flag is 1. Writing 1 in bit 0 to select 5 clears the flag.
- R10: Busy is 1 from the cycle after the start pulse until the frame is finished. Writes to selects 0, 1 and 3 are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | PAGE_W | Configuration write data |
| frm_start | input | 1 | Frame announce pulse, accepted when busy is 0 |
| frm_len | input | LEN_W | Frame length in bytes (at most MAX_FRAME) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte |
| busy | output | 1 | A frame is being handled |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | PAGE_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | PAGE_W | Current page pointer |
| rx_status | output | 8 | Status of the last stored frame |
| rx_flag | output | 1 | Receive-complete flag |

## Verification
The results fall due at different times:
- Each memory write appears on the port one cycle after the stream handshake or pad step that causes it.
- The four descriptor writes follow the last data write on consecutive cycles.
- The current page, status and flag change on the same edge on which busy falls.

The bench drives and samples on falling edges. It records memory writes as they appear, and compares the descriptor, the data bytes, the write count and the pointer state only once busy has been observed low. Busy itself is checked on the first falling edge after the start pulse.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DRAIN = 3'd1,
    S_DATA  = 3'd2,
    S_HDR   = 3'd3,
    S_DONE  = 3'd4
  } rxr_state_t;

  localparam logic [2:0] SEL_FIRST = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_BND   = 3'd2;
  localparam logic [2:0] SEL_CUR   = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_CLR   = 3'd5;

  localparam logic [7:0] ST_OK    = 8'h01;
  localparam logic [7:0] ST_GROUP = 8'h20;

  localparam int DESC_BYTES = 4;
  localparam int FCS_BYTES  = 4;
endpackage

// File: rtl/rxr_ring_regs.sv
module rxr_ring_regs
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [PAGE_W-1:0] done_next,
  input  logic [7:0]        done_status,
  output logic [PAGE_W-1:0] first_pg,
  output logic [PAGE_W-1:0] end_pg,
  output logic [PAGE_W-1:0] bnd_pg,
  output logic [PAGE_W-1:0] cur_pg,
  output logic              halt,
  output logic              flag,
  output logic [7:0]        status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      first_pg <= '0;
      end_pg   <= '0;
      bnd_pg   <= '0;
      cur_pg   <= '0;
      halt     <= 1'b1;
      flag     <= 1'b0;
      status   <= 8'h00;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_FIRST: if (!busy) first_pg <= cfg_wdata;
          SEL_END:   if (!busy) end_pg   <= cfg_wdata;
          SEL_BND:   bnd_pg <= cfg_wdata;
          SEL_CUR:   if (!busy) cur_pg   <= cfg_wdata;
          SEL_CTRL:  halt <= cfg_wdata[0];
          SEL_CLR:   if (cfg_wdata[0]) flag <= 1'b0;
          default: ;
        endcase
      end
      // completion of a stored frame overrides a same-cycle clear
      if (done) begin
        cur_pg <= done_next;
        flag   <= 1'b1;
        status <= done_status;
      end
    end
  end
endmodule

// File: rtl/rxr_space_check.sv
module rxr_space_check
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              room_ok
);
  // a full-size frame plus its checksum must fit; work in whole pages
  localparam int NEED_BYTES = MAX_FRAME + FCS_BYTES;
  localparam int NEED_PG    = (NEED_BYTES + 255) / 256;

  logic signed [PAGE_W+1:0] free_pg;

  always_comb begin
    if (cur_pg < bnd_pg)
      free_pg = $signed({2'b00, bnd_pg}) - $signed({2'b00, cur_pg});
    else
      free_pg = ($signed({2'b00, end_pg}) - $signed({2'b00, first_pg}))
              - ($signed({2'b00, cur_pg}) - $signed({2'b00, bnd_pg}));
    room_ok = (int'(free_pg) >= NEED_PG);
  end
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic [15:0]       total_len,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int SUM_W = PAGE_W + 10;

  logic [SUM_W-1:0] adv;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    adv = SUM_W'(({1'b0, total_len} + 17'(FCS_BYTES + 255)) >> 8);
    sum = SUM_W'(cur_pg) + adv;
    if (sum >= SUM_W'(end_pg))
      wrapped = sum - (SUM_W'(end_pg) - SUM_W'(first_pg));
    else
      wrapped = sum;
    next_pg = wrapped[PAGE_W-1:0];
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60,
  parameter int MAX_FRAME = 1514,
  localparam int ADDR_W   = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic [7:0]        rx_status,
  output logic              rx_flag
);
  rxr_state_t        state_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  last_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [PAGE_W-1:0] base_q;
  logic [PAGE_W-1:0] next_q;
  logic [15:0]       total_q;
  logic              group_q;
  logic [1:0]        hidx_q;

  logic [PAGE_W-1:0] first_pg, end_pg, bnd_pg, cur_pg;
  logic              halt;
  logic              room_ok;
  logic [LEN_W-1:0]  stored_c;
  logic [15:0]       total_c;
  logic [PAGE_W-1:0] next_c;
  logic [7:0]        status_c;
  logic              have_byte;
  logic              fire;
  logic              done;

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign status_c = ST_OK | (group_q ? ST_GROUP : 8'h00);
  assign cur_page = cur_pg;

  rxr_ring_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .done       (done),
    .done_next  (next_q),
    .done_status(status_c),
    .first_pg   (first_pg),
    .end_pg     (end_pg),
    .bnd_pg     (bnd_pg),
    .cur_pg     (cur_pg),
    .halt       (halt),
    .flag       (rx_flag),
    .status     (rx_status)
  );

  rxr_space_check #(.PAGE_W(PAGE_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .first_pg(first_pg),
    .end_pg  (end_pg),
    .bnd_pg  (bnd_pg),
    .cur_pg  (cur_pg),
    .room_ok (room_ok)
  );

  // short frames are stored at the minimum size
  always_comb begin
    stored_c = (frm_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : frm_len;
    total_c  = 16'(stored_c) + 16'(DESC_BYTES);
  end

  rxr_next_page #(.PAGE_W(PAGE_W)) u_next (
    .cur_pg   (cur_pg),
    .first_pg (first_pg),
    .end_pg   (end_pg),
    .total_len(total_c),
    .next_pg  (next_c)
  );

  assign have_byte = (cnt_q < len_q);
  assign fire      = have_byte ? in_valid : 1'b1;
  assign in_ready  = ((state_q == S_DATA) && have_byte) || (state_q == S_DRAIN);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [PAGE_W-1:0] fp,
                                                  input logic [PAGE_W-1:0] ep);
    logic [ADDR_W:0] n;
    n = {1'b0, a} + 1'b1;
    if (n == {1'b0, ep, 8'h00}) return {fp, 8'h00};
    return n[ADDR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      last_q    <= '0;
      wr_addr_q <= '0;
      base_q    <= '0;
      next_q    <= '0;
      total_q   <= '0;
      group_q   <= 1'b0;
      hidx_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (frm_start) begin
            cnt_q   <= '0;
            len_q   <= frm_len;
            group_q <= 1'b0;
            if (halt || !room_ok) begin
              if (frm_len != '0) state_q <= S_DRAIN;
            end else begin
              state_q   <= S_DATA;
              last_q    <= stored_c - LEN_W'(1);
              total_q   <= total_c;
              next_q    <= next_c;
              base_q    <= cur_pg;
              wr_addr_q <= {cur_pg, 8'(DESC_BYTES)};
            end
          end
        end
        S_DRAIN: begin
          if (in_valid) begin
            cnt_q <= cnt_q + LEN_W'(1);
            if (cnt_q == len_q - LEN_W'(1)) state_q <= S_IDLE;
          end
        end
        S_DATA: begin
          if (fire) begin
            mem_we    <= 1'b1;
            mem_addr  <= wr_addr_q;
            mem_wdata <= have_byte ? in_data : 8'h00;
            if (have_byte && cnt_q == '0) group_q <= in_data[0];
            wr_addr_q <= step_addr(wr_addr_q, first_pg, end_pg);
            cnt_q     <= cnt_q + LEN_W'(1);
            if (cnt_q == last_q) begin
              state_q <= S_HDR;
              hidx_q  <= '0;
            end
          end
        end
        S_HDR: begin
          mem_we   <= 1'b1;
          mem_addr <= {base_q, 8'(hidx_q)};
          case (hidx_q)
            2'd0:    mem_wdata <= status_c;
            2'd1:    mem_wdata <= 8'(next_q);
            2'd2:    mem_wdata <= total_q[7:0];
            default: mem_wdata <= total_q[15:8];
          endcase
          hidx_q <= hidx_q + 2'd1;
          if (hidx_q == 2'd3) state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_we,
  input logic [PAGE_W+7:0] mem_addr,
  input logic [PAGE_W-1:0] cur_page,
  input logic [7:0]        rx_status,
  input logic              rx_flag,
  input logic [PAGE_W-1:0] first_pg,
  input logic [PAGE_W-1:0] end_pg
);
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we); // R2

  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (mem_we && first_pg < end_pg) |->
      (mem_addr >= {first_pg, 8'h00} && mem_addr < {end_pg, 8'h00})); // R5

  AST_CUR_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cur_page)); // R10

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_flag) |-> $fell(busy)); // R9

  AST_STATUS_FORM: assert property (@(posedge clk) disable iff (rst)
    (rx_status == 8'h00 || rx_status == 8'h01 || rx_status == 8'h21)); // R8
endmodule

bind rx_ring_writer rxr_checker #(.PAGE_W(PAGE_W)) u_rxr_checker (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .cur_page (cur_page),
  .rx_status(rx_status),
  .rx_flag  (rx_flag),
  .first_pg (first_pg),
  .end_pg   (end_pg)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 8;
  localparam int LEN_W  = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_sel = '0;
  logic [PAGE_W-1:0] cfg_wdata = '0;
  logic              frm_start = 1'b0;
  logic [LEN_W-1:0]  frm_len = '0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready, busy, mem_we, rx_flag;
  logic [15:0]       mem_addr;
  logic [7:0]        mem_wdata, rx_status;
  logic [PAGE_W-1:0] cur_page;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frm_start(frm_start), .frm_len(frm_len), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_page(cur_page), .rx_status(rx_status), .rx_flag(rx_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int wr_cnt = 0;
  logic [7:0] tb_mem [0:65535];
  logic [7:0] fbuf [0:2047];
  int m_first, m_end, m_bnd, m_cur;
  bit m_halt;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mem_we) begin
      tb_mem[mem_addr] = mem_wdata;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = PAGE_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_first = val;
      3'd1: m_end = val;
      3'd2: m_bnd = val;
      3'd3: m_cur = val;
      3'd4: m_halt = val[0];
      default: ;
    endcase
  endtask

  function automatic bit room(input int c, input int b, input int f, input int e);
    int fp;
    if (c < b) fp = b - c;
    else fp = (e - f) - (c - b);
    return (fp * 256) >= 1518;
  endfunction

  function automatic int nextp(input int c, input int total, input int f, input int e);
    int n;
    n = c + (total + 4 + 255) / 256;
    if (n >= e) n = n - (e - f);
    return n & 255;
  endfunction

  task automatic run_frame(input int len, input bit poke, input string dtag);
    bit acc;
    int w0, c0, i, stored, total, nx, st, a, bad, badpad;
    bit hs, flag0;
    logic [7:0] st0;
    acc = !m_halt && room(m_cur, m_bnd, m_first, m_end);
    w0 = wr_cnt; c0 = m_cur; flag0 = rx_flag; st0 = rx_status;
    @(negedge clk);
    frm_start = 1'b1; frm_len = LEN_W'(len);
    @(negedge clk);
    frm_start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    i = 0;
    while (busy) begin
      if (poke && i == 2) begin cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 8'h55; end
      else cfg_we = 1'b0;
      if (in_ready && i < len && ($urandom % 4) != 0) begin
        in_valid = 1'b1; in_data = fbuf[i];
      end else in_valid = 1'b0;
      hs = in_valid && in_ready;
      @(negedge clk);
      if (hs) i++;
    end
    in_valid = 1'b0; cfg_we = 1'b0;
    chk(i == len, "R2 all bytes taken", i, len);
    if (!acc) begin
      chk(wr_cnt == w0, {dtag, " no write on drop"}, wr_cnt - w0, 0);
      chk(int'(cur_page) == c0, {dtag, " page kept on drop"}, int'(cur_page), c0);
      chk(rx_flag == flag0 && rx_status == st0, {dtag, " flag/status kept"},
          int'(rx_status), int'(st0));
    end else begin
      stored = (len < 60) ? 60 : len;
      total = stored + 4;
      nx = nextp(c0, total, m_first, m_end);
      st = (fbuf[0][0] && len > 0) ? 8'h21 : 8'h01;
      chk(wr_cnt - w0 == total, "R5 write count", wr_cnt - w0, total);
      chk(tb_mem[c0*256] == 8'(st), "R6 descriptor status", int'(tb_mem[c0*256]), st);
      chk(tb_mem[c0*256+1] == 8'(nx), "R7 descriptor next page", int'(tb_mem[c0*256+1]), nx);
      chk({tb_mem[c0*256+3], tb_mem[c0*256+2]} == 16'(total), "R4 descriptor length",
          int'({tb_mem[c0*256+3], tb_mem[c0*256+2]}), total);
      bad = 0; badpad = 0;
      for (int k = 0; k < stored; k++) begin
        a = c0 * 256 + 4 + k;
        if (a >= m_end * 256) a = a - m_end * 256 + m_first * 256;
        if (k < len) begin if (tb_mem[a] !== fbuf[k]) bad++; end
        else if (tb_mem[a] !== 8'h00) badpad++;
      end
      chk(bad == 0, "R5 data placement", bad, 0);
      if (len < 60) chk(badpad == 0, "R4 zero padding", badpad, 0);
      chk(int'(cur_page) == nx, poke ? "R10 page write ignored while busy" : "R9 page advanced",
          int'(cur_page), nx);
      chk(rx_flag == 1'b1, "R9 flag set", int'(rx_flag), 1);
      chk(int'(rx_status) == st, "R8 status latched", int'(rx_status), st);
      m_cur = nx;
    end
  endtask

  task automatic fill(input int len, input logic [7:0] b0);
    for (int k = 0; k < len; k++) fbuf[k] = 8'($urandom);
    fbuf[0] = b0;
  endtask

  initial begin
    int seed_init;
    int len;
    seed_init = $urandom(20240607);
    m_first = 0; m_end = 0; m_bnd = 0; m_cur = 0; m_halt = 1'b1;
    for (int a = 0; a < 65536; a++) tb_mem[a] = 8'hA5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_page == 0 && rx_status == 0, "R1 pointer/status reset", int'(cur_page), 0);
    chk(!rx_flag && !busy && !in_ready && !mem_we, "R1 control outputs reset",
        int'({rx_flag, busy, in_ready, mem_we}), 0);

    cfg(3'd0, 8'h40); cfg(3'd1, 8'h80); cfg(3'd2, 8'h40); cfg(3'd3, 8'h40);
    // still halted from reset
    fill(100, 8'h10); run_frame(100, 1'b0, "R2");
    cfg(3'd4, 0);
    chk(rx_flag == 1'b0, "R1 flag still clear", int'(rx_flag), 0);

    fill(20, 8'h02); run_frame(20, 1'b0, "R4");
    fill(100, 8'h01); run_frame(100, 1'b0, "R8");
    cfg(3'd5, 1);
    chk(rx_flag == 1'b0, "R9 flag cleared", int'(rx_flag), 0);

    // wrap across ring end
    cfg(3'd3, 8'h7F); cfg(3'd2, 8'h7F);
    fill(600, 8'h00); run_frame(600, 1'b0, "R5");

    // admission thresholds
    cfg(3'd3, 8'h50); cfg(3'd2, 8'h56);
    fill(1514, 8'h04); run_frame(1514, 1'b0, "R3");
    cfg(3'd3, 8'h50); cfg(3'd2, 8'h55);
    fill(80, 8'h04); run_frame(80, 1'b0, "R3");
    cfg(3'd3, 8'h7C); cfg(3'd2, 8'h40);
    fill(80, 8'h04); run_frame(80, 1'b0, "R3");
    cfg(3'd3, 8'h50); cfg(3'd2, 8'h4B);
    fill(61, 8'h05); run_frame(61, 1'b0, "R3");

    // page write during a frame
    cfg(3'd2, m_cur);
    fill(300, 8'h06); run_frame(300, 1'b1, "R10");

    // halt again, then resume
    cfg(3'd4, 1);
    fill(40, 8'h00); run_frame(40, 1'b0, "R2");
    cfg(3'd4, 0);

    for (int n = 0; n < 40; n++) begin
      if (n % 3 == 0) len = $urandom_range(1, 70);
      else len = $urandom_range(1, 1514);
      if (n % 4 == 0) cfg(3'd2, $urandom_range(8'h40, 8'h7F));
      else cfg(3'd2, m_cur);
      fill(len, 8'($urandom));
      run_frame(len, 1'b0, "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule